// File: doc/BRIEF.md
# Divided Clock-Enable Source Selector

This block produces six consumer clock enables from one system clock. Every clock in the design is a single-cycle strobe. The block has two kinds of input strobe. The first is one auxiliary PLL strobe. The second is a bank of six frequency-generator strobes. A 32-bit configuration register holds a 5-bit field for each consumer. The field chooses which input strobe that consumer follows, or stops the consumer. The field also picks a small divide ratio, which is decoded through a four-entry table.

Each consumer counts the pulses of its chosen input. It emits one output strobe when the count completes. A parameter selects the table variant. The legacy variant offers ratios 1, 2 and 4. The extended variant also offers divide-by-3. One write updates all six fields together. Any consumer whose field changed restarts its count.

Top module: `clksel_array`

## Requirements
- R1: Consumer i (0..5) is configured by bits [5i+4:5i] of the written word. Bits 31:30 are not stored. The read port returns the last written word with bits 31:30 read as zero.
- R2: A source code (field bits 4:2) of 0 stops the consumer. Its output stays low, and its pulse count stays at zero until it is re-enabled.
- R3: Source code 1 follows the auxiliary PLL strobe. Source codes 2 to 7 follow frequency-generator strobes 0 to 5 in that order.
- R4: The legacy variant (EXTENDED=0) decodes divide code (field bits 1:0) values 0, 1, 2 and 3 to divide ratios 1, 4, 1 and 2.
- R5: The extended variant (EXTENDED=1) decodes divide code 2 to a ratio of 3. The other codes decode as in R4.
- R6: For a ratio N, the output is high for exactly one cycle, in the cycle after each Nth selected input pulse counted since the last restart. In every other cycle the output is low.
- R7: A write that changes a consumer's field resets that consumer's count. The consumer's output is low in the following cycle, even if an input pulse arrives in the same cycle as the write.
- R8: A write that leaves a consumer's field unchanged does not disturb that consumer's count. Consumers are independent of each other.
- R9: After reset, the configuration reads zero, all consumers are stopped and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| aux_stb | input | 1 | Auxiliary PLL strobe |
| gen_stb | input | 6 | Frequency-generator strobes |
| out_stb | output | 6 | Divided consumer strobes |

## Verification
Two events can fall in the same cycle: a configuration write, and the selected input pulse that would complete a division. In that case the restart must win. The sweep writes new fields while the inputs pulse at random. Many writes therefore land on a completing pulse, and directed sequences force this case on purpose. The bench keeps its own pulse count for each consumer, derived from the ratio tables. It expects a low output and a fresh count whenever the field changes. A rewrite of the same value must leave the count running.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int FIELD_W = 5;
  localparam int SRC_W   = 3;
  localparam int DCODE_W = 2;
  localparam int DIV_W   = 3;
  localparam int CNT_W   = 2;

  // Non-monotonic ratio table; slot 2 differs by variant.
  function automatic logic [DIV_W-1:0] div_of(input logic [DCODE_W-1:0] code,
                                              input bit ext);
    case (code)
      2'd0:    div_of = 3'd1;
      2'd1:    div_of = 3'd4;
      2'd2:    div_of = ext ? 3'd3 : 3'd1;
      default: div_of = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/clksel_src_mux.sv
module clksel_src_mux #(
  parameter int NUM_GEN = 6
) (
  input  logic [clksel_pkg::SRC_W-1:0] src,
  input  logic                         aux,
  input  logic [NUM_GEN-1:0]           gen,
  output logic                         pulse
);
  always_comb begin
    pulse = 1'b0;
    if (src == 3'd1) begin
      pulse = aux;
    end else if (src >= 3'd2) begin
      for (int k = 0; k < NUM_GEN; k++) begin
        if (int'(src) - 2 == k) pulse = gen[k];
      end
    end
  end
endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
  parameter bit EXTENDED = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           restart,
  input  logic [clksel_pkg::DCODE_W-1:0] dcode,
  input  logic                           pulse,
  output logic                           out_q
);
  import clksel_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_w;
  logic             last_w;

  assign div_w  = div_of(dcode, EXTENDED);
  assign last_w = ({1'b0, cnt_q} == div_w - 3'd1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (pulse) begin
      out_q <= last_w;
      cnt_q <= last_w ? '0 : cnt_q + 1'b1;
    end else begin
      out_q <= 1'b0;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} < div_w));
  assert_no_pulse_low_R6: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> !out_q);
  assert_restart_low_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!out_q && cnt_q == '0));
endmodule

// File: rtl/clksel_chan.sv
module clksel_chan #(
  parameter int NUM_GEN  = 6,
  parameter bit EXTENDED = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [clksel_pkg::FIELD_W-1:0] field_cur,
  input  logic [clksel_pkg::FIELD_W-1:0] field_new,
  input  logic                           aux,
  input  logic [NUM_GEN-1:0]             gen,
  output logic                           out
);
  import clksel_pkg::*;

  logic             pulse;
  logic             restart;
  logic [SRC_W-1:0] src;

  assign src     = field_cur[FIELD_W-1:DCODE_W];
  assign restart = wr && (field_new != field_cur);

  clksel_src_mux #(.NUM_GEN(NUM_GEN)) u_mux (
    .src(src), .aux(aux), .gen(gen), .pulse(pulse)
  );

  clksel_div #(.EXTENDED(EXTENDED)) u_div (
    .clk(clk), .rst(rst), .restart(restart),
    .dcode(field_cur[DCODE_W-1:0]), .pulse(pulse), .out_q(out)
  );

  assert_off_low_R2: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |=> !out);
endmodule

// File: rtl/clksel_array.sv
module clksel_array #(
  parameter int NUM_CONS = 6,
  parameter int NUM_GEN  = 6,
  parameter int REG_W    = 32,
  parameter bit EXTENDED = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                aux_stb,
  input  logic [NUM_GEN-1:0]  gen_stb,
  output logic [NUM_CONS-1:0] out_stb
);
  import clksel_pkg::*;
  localparam int CFG_W = NUM_CONS * FIELD_W;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[CFG_W-1:0];
  end

  assign cfg_rdata = REG_W'(cfg_q);

  for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
    clksel_chan #(.NUM_GEN(NUM_GEN), .EXTENDED(EXTENDED)) u_chan (
      .clk(clk), .rst(rst), .wr(cfg_we),
      .field_cur(cfg_q[i*FIELD_W +: FIELD_W]),
      .field_new(cfg_wdata[i*FIELD_W +: FIELD_W]),
      .aux(aux_stb), .gen(gen_stb), .out(out_stb[i])
    );
  end

  assert_rdata_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata == REG_W'($past(cfg_wdata[CFG_W-1:0]))));
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (cfg_rdata == '0 && out_stb == '0));
endmodule

// File: tb/sim_clksel_array.sv
module sim_clksel_array;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        aux_stb = 1'b0;
  logic [5:0]  gen_stb = '0;
  logic [31:0] rd0, rd1;
  logic [5:0]  out0, out1;

  int checks = 0;
  int errors = 0;
  logic [4:0]  mf [6];
  int          mc [2][6];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  clksel_array #(.EXTENDED(1'b0)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd0), .aux_stb(aux_stb), .gen_stb(gen_stb), .out_stb(out0));
  clksel_array #(.EXTENDED(1'b1)) u1 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd1), .aux_stb(aux_stb), .gen_stb(gen_stb), .out_stb(out1));

  function automatic int tdiv(input int ext, input logic [1:0] d);
    case (d)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return ext ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic a,
                      input logic [5:0] g, input string tag);
    logic [5:0] ex [2];
    for (int e = 0; e < 2; e++) begin
      for (int i = 0; i < 6; i++) begin
        logic [2:0] s;
        logic       p;
        int         n;
        s = mf[i][4:2];
        p = (s == 3'd0) ? 1'b0 : (s == 3'd1) ? a : g[s - 3'd2];
        n = tdiv(e, mf[i][1:0]);
        ex[e][i] = 1'b0;
        if (we && wd[5*i +: 5] != mf[i]) begin
          mc[e][i] = 0;
        end else if (p) begin
          if (mc[e][i] == n - 1) begin
            ex[e][i] = 1'b1;
            mc[e][i] = 0;
          end else mc[e][i]++;
        end
      end
    end
    cfg_we = we; cfg_wdata = wd; aux_stb = a; gen_stb = g;
    @(posedge clk);
    @(negedge clk);
    if (we) for (int i = 0; i < 6; i++) mf[i] = wd[5*i +: 5];
    chk({tag, " legacy out"}, {26'd0, out0}, {26'd0, ex[0]});
    chk({tag, " extended out"}, {26'd0, out1}, {26'd0, ex[1]});
    if (we) chk("R1 readback", rd0, {2'b00, wd[29:0]});
    cfg_we = 1'b0;
  endtask

  task automatic pulses(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      lfsr = nxt(lfsr);
      step(1'b0, '0, lfsr[0] | k[0], (k % 3 == 0) ? 6'h3F : lfsr[6:1], tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      mf[i] = '0; mc[0][i] = 0; mc[1][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset rdata", rd0, 32'd0);
    chk("R9 reset out", {26'd0, out0 | out1}, 32'd0);

    // Sweep every field value in every slot, others scrambled.
    for (int c = 0; c < 6; c++) begin
      for (int f = 0; f < 32; f++) begin
        logic [31:0] w;
        lfsr = nxt(lfsr);
        w = {lfsr, nxt(lfsr)};
        w[5*c +: 5] = f[4:0];
        step(1'b1, w, 1'b1, 6'h3F, "R3/R4/R5/R7 sweep");
        pulses(14, "R3/R4/R5/R6 sweep");
      end
    end

    // R7: write lands on a completing pulse.
    step(1'b1, 32'h0000_0005, 1'b0, '0, "R7 setup");
    step(1'b0, '0, 1'b1, '0, "R7");
    step(1'b0, '0, 1'b1, '0, "R7");
    step(1'b0, '0, 1'b1, '0, "R7");
    step(1'b1, 32'h0000_0006, 1'b1, '0, "R7 restart");
    for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, '0, "R7 after restart");

    // R8: identical rewrite mid-count.
    step(1'b1, 32'h0000_0005, 1'b0, '0, "R8 setup");
    step(1'b0, '0, 1'b1, '0, "R8");
    step(1'b0, '0, 1'b1, '0, "R8");
    step(1'b1, 32'h0000_0005, 1'b1, '0, "R8 same rewrite");
    step(1'b0, '0, 1'b1, '0, "R8 completes");
    step(1'b0, '0, 1'b0, '0, "R8");

    // R2: stopped consumers ignore pulses, then count from zero.
    step(1'b1, 32'hC000_0000, 1'b1, 6'h3F, "R2 disable");
    pulses(10, "R2 stopped");
    step(1'b1, {2'b00, {6{5'b00101}}}, 1'b0, '0, "R2 re-enable");
    pulses(12, "R2 recount");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(1_500_000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule